// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces a repeating interrupt suitable for an operating-system tick. A down-counter steps toward zero once per count tick. Each count tick is made by a prescaler that counts pulses on a clock-enable input, so the tick period is a fixed number of input enables. When the counter lands on zero, a sticky event flag is raised. The count tick after that reloads the counter from a programmable reload register, so the period repeats without software help.

Software reaches four registers through a simple synchronous bus made of address, write strobe, write data and combinational read data. The control register at 0x00 holds count enable in bit 0 and interrupt mask in bit 1. The reload register is at 0x04. The read-only live count is at 0x08. The event register is at 0x10 and holds the flag in bit 0. The interrupt output is a level that follows the flag gated by the mask.

Top module: `pit_timer`

## Requirements
- R1: While count enable (control bit 0) is 1, every PRESCALE pulses on `tick_en` produce one count tick. Each count tick decrements a non-zero counter by one.
- R2: A count tick that takes the counter from 1 to 0 sets the event flag. A counter that sits at 0 with a reload value of 0 never sets the flag.
- R3: A count tick while the counter is 0 loads the reload value, so a reload value R gives a period of R+1 count ticks.
- R4: `irq` is 1 exactly when the event flag is set and the interrupt mask (control bit 1) is 1.
- R5: The event register at address 0x10 holds the flag in bit 0. Writing 1 to bit 0 clears the flag, writing 0 leaves it unchanged, and all other bits read 0.
- R6: The flag stays set when the counter reaches zero again before software clears it.
- R7: A write to the reload register at 0x04 immediately loads the written value into the counter and clears the prescaler, so the next count tick needs a full PRESCALE enables.
- R8: While count enable is 0, the counter keeps its value and the prescaler is held cleared.
- R9: When a flag clear and a 1-to-0 count tick fall in the same cycle, the flag ends up set.
- R10: After reset, every register reads 0 and `irq` is 0. The live count is readable at address 0x08 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Clock-enable pulses feeding the prescaler |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt: flag AND mask |

## Verification
The bench builds the timer with PRESCALE=3 and a 32-bit counter. With these values, every reload value from 1 to 6 can be swept through its full countdown, its zero event and its reload in a few hundred cycles. The sweep runs under two enable patterns: enables on every cycle, and enables on alternate cycles. The small prescale ratio also lets the bench park the prescaler one enable short of a tick. From that position it hits the reload-abort, the enable-off hold and the same-cycle set-versus-clear corners deterministically.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 4,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0]   PS_LAST = PS_W'(PRESCALE - 1);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_EVENT = ADDR_W'(5'h10);
  localparam logic [CNT_W-1:0]  ONE     = CNT_W'(1);

  logic             cen, mask, flag;
  logic [PS_W-1:0]  psc;
  logic [CNT_W-1:0] count, reload;
  logic             wr_ctrl, wr_load, wr_clr, tick, zero_hit;

  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_load  = bus_we && (bus_addr == A_LOAD);
  assign wr_clr   = bus_we && (bus_addr == A_EVENT) && bus_wdata[0];
  assign tick     = cen && tick_en && (psc == PS_LAST) && !wr_load;
  assign zero_hit = tick && (count == ONE);
  assign irq      = flag && mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cen  <= 1'b0;
      mask <= 1'b0;
    end else if (wr_ctrl) begin
      cen  <= bus_wdata[0];
      mask <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cen || wr_load)
      psc <= '0;
    else if (tick_en)
      psc <= (psc == PS_LAST) ? '0 : psc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload <= '0;
      count  <= '0;
    end else if (wr_load) begin
      reload <= bus_wdata;
      count  <= bus_wdata;
    end else if (tick) begin
      count  <= (count == '0) ? reload : count - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (zero_hit) flag <= 1'b1;
    else if (wr_clr)   flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(CNT_W-2){1'b0}}, mask, cen};
      A_LOAD:  bus_rdata = reload;
      A_COUNT: bus_rdata = count;
      A_EVENT: bus_rdata = {{(CNT_W-1){1'b0}}, flag};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module pit_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cen,
  input logic             mask,
  input logic             flag,
  input logic             tick,
  input logic             wr_load,
  input logic             wr_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             irq
);
  a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count > 1 |=> count == $past(count) - 1);
  a_r2_flag_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count == 1 |=> flag && count == 0);
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mask |-> !irq);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !wr_clr |=> flag);
  a_r7_load_now: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> count == $past(bus_wdata));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cen && !wr_load |=> $stable(count));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen(cen), .mask(mask), .flag(flag),
  .tick(tick), .wr_load(wr_load), .wr_clr(wr_clr), .count(count),
  .bus_wdata(bus_wdata), .irq(irq)
);

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
  localparam int CLK_PER = 10;
  localparam int P       = 3;
  localparam int W       = 32;
  localparam int LIMIT   = 100000;

  logic clk = 0, rst_n = 0, tick_en = 0, bus_we = 0;
  logic [4:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic         irq;
  int total = 0, bad = 0;
  logic dense = 1'b1;

  always #(CLK_PER/2) clk = ~clk;

  pit_timer #(.CNT_W(W), .PRESCALE(P), .ADDR_W(5)) u_pit_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [W-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [W-1:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      if (!dense) begin @(negedge clk); tick_en = 0; end
    end
    @(negedge clk); tick_en = 0;
  endtask

  logic [W-1:0] v;

  initial begin
    repeat (LIMIT) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(5'h00, v); chk("R10 ctrl reset", v, 0);
    rd(5'h04, v); chk("R10 reload reset", v, 0);
    rd(5'h08, v); chk("R10 count reset", v, 0);
    rd(5'h10, v); chk("R10 event reset", v, 0);
    chk("R10 irq reset", irq, 0);

    for (int d = 0; d < 2; d++) begin
      dense = (d == 0);
      for (int r = 1; r <= 6; r++) begin
        wr(5'h10, 1);
        wr(5'h00, 3);
        wr(5'h04, r);
        for (int k = 1; k <= r; k++) begin
          pulses(P);
          rd(5'h08, v); chk("R1 countdown", v, r - k);
          rd(5'h10, v); chk("R2 flag at zero", v, (k == r) ? 1 : 0);
          chk("R4 irq follows flag", irq, (k == r) ? 1 : 0);
        end
        pulses(P);
        rd(5'h08, v); chk("R3 reload after zero", v, r);
        pulses(P * r);
        rd(5'h10, v); chk("R6 flag sticky", v, 1);
        rd(5'h08, v); chk("R6 count at zero", v, 0);
      end
    end
    dense = 1;

    wr(5'h10, 0);
    rd(5'h10, v); chk("R5 zero write ignored", v, 1);
    wr(5'h10, '1);
    rd(5'h10, v); chk("R5 w1c clears, others 0", v, 0);

    wr(5'h00, 1);
    wr(5'h04, 2);
    pulses(2 * P);
    rd(5'h10, v); chk("R4 flag set unmasked", v, 1);
    chk("R4 irq masked", irq, 0);
    wr(5'h00, 3);
    chk("R4 irq unmasked", irq, 1);
    wr(5'h10, 1);
    chk("R4 irq drops on clear", irq, 0);

    wr(5'h04, 5);
    pulses(P - 1);
    wr(5'h04, 4);
    rd(5'h08, v); chk("R7 load immediate", v, 4);
    pulses(P - 1);
    rd(5'h08, v); chk("R7 prescaler cleared", v, 4);
    pulses(1);
    rd(5'h08, v); chk("R7 first tick", v, 3);

    pulses(P - 1);
    wr(5'h00, 2);
    pulses(3 * P);
    rd(5'h08, v); chk("R8 hold when off", v, 3);
    wr(5'h00, 3);
    pulses(P - 1);
    rd(5'h08, v); chk("R8 prescaler held clear", v, 3);
    pulses(1);
    rd(5'h08, v); chk("R8 resumes", v, 2);

    wr(5'h10, 1);
    wr(5'h04, 1);
    pulses(P - 1);
    @(negedge clk);
    tick_en = 1; bus_addr = 5'h10; bus_wdata = 1; bus_we = 1;
    @(negedge clk);
    tick_en = 0; bus_we = 0;
    rd(5'h10, v); chk("R9 set beats clear", v, 1);
    rd(5'h08, v); chk("R9 count zero", v, 0);

    wr(5'h10, 1);
    wr(5'h04, 0);
    pulses(4 * P);
    rd(5'h08, v); chk("R2 reload zero stays", v, 0);
    rd(5'h10, v); chk("R2 reload zero no flag", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule